// File: doc/BRIEF.md
# Private Peripheral Window Access Router

This block sits between a core's register-bus master and the small set of register devices that live in a 1 MiB private peripheral window. It accepts one request per cycle, made up of an address, a read/write flag, a size code, write data, a privileged flag and a secure flag. It decodes the address and steers the request to the timer register port or to the system-control/interrupt register port. When no region claims the address, a built-in responder answers instead. The selected port answers combinationally in the cycle of acceptance, and the router registers the outcome into a response that appears exactly one cycle later.

Regions can overlap and are resolved in a fixed order: the timer beats the system registers, and the system registers beat the default responder. The default responder's answer depends on privilege. A privileged request reads as zero, its writes are dropped, and it completes without error. An unprivileged request gets a bus error. A parameter enables a security extension, which adds a 4 KiB alias page. A secure access to that page reaches the system-register port with its forwarded secure flag cleared, so the downstream logic selects the non-secure banked copy. The requester's own flag stays visible on a separate output.

Top module: `ppb_router`

## Requirements
- R1: An address outside 0xE000_0000..0xE00F_FFFF selects no downstream port and gets an error response with zero data.
- R2: Addresses 0xE000_E010..0xE000_E0FF select the timer port (tmr_sel) and never the system port. The port receives dn_offset equal to address bits [11:0] and dn_secure equal to req_secure.
- R3: In the page at 0xE000_E000 the system port (sys_sel) is selected and sys_reg reports a code. Offsets 0x004..0x007 give code 0. Offsets 0x100..0x7EF give code 1. Offsets 0xD00..0xD3F give code 2. Offsets 0xF00..0xF03 give code 3. In all these cases dn_secure equals req_secure.
- R4: A privileged request to any unclaimed address inside the window selects no port. It gets zero read data and no error. This includes page holes and the rest of the window.
- R5: An unprivileged request to an unclaimed address inside the window gets an error response with zero data.
- R6: With SEC_EXT=1, a secure access to 0xE002_E000..0xE002_EFFF at a system sub-region offset from R3 selects the system port. It uses the same offset and sub-region code, with dn_secure=0 and dn_orig_secure=1. Timer offsets and holes in the alias page are unclaimed.
- R7: A non-secure access to the alias page is unclaimed: zero data and no error when privileged, error when unprivileged.
- R8: With SEC_EXT=0 the alias page is unclaimed even for secure accesses.
- R9: req_ready is always high. Every accepted request produces rsp_valid high in the next cycle only, so back-to-back requests give back-to-back responses.
- R10: A write response carries zero data, and any error response carries zero data. The error bit of a selected port is passed through unchanged.
- R11: Size codes 0, 1, 2 and 3 (1, 2, 4 and 8 bytes) are all accepted and forwarded unchanged on dn_size.
- R12: During and right after reset, rsp_valid is low and neither port is selected while req_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (always high) |
| req_addr | input | 32 | Byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Size code, 2^code bytes |
| req_wdata | input | 64 | Write data |
| req_priv | input | 1 | Privileged requester |
| req_secure | input | 1 | Secure requester |
| tmr_sel | output | 1 | Timer port select |
| sys_sel | output | 1 | System register port select |
| sys_reg | output | 2 | System sub-region code |
| dn_offset | output | 12 | Offset within the 4 KiB page |
| dn_write | output | 1 | Forwarded write flag |
| dn_size | output | 2 | Forwarded size code |
| dn_wdata | output | 64 | Forwarded write data |
| dn_priv | output | 1 | Forwarded privilege flag |
| dn_secure | output | 1 | Forwarded secure flag, used for bank selection |
| dn_orig_secure | output | 1 | Requester's original secure flag |
| tmr_rdata | input | 64 | Timer read data |
| tmr_err | input | 1 | Timer error |
| sys_rdata | input | 64 | System port read data |
| sys_err | input | 1 | System port error |
| rsp_valid | output | 1 | Response present |
| rsp_rdata | output | 64 | Response read data |
| rsp_err | output | 1 | Response error |

## Verification
The bench probes the edges of every range: the first and last timer offsets, the byte just below the timer, and the bytes just past the interrupt and control ranges. A decoder with an off-by-one or a wrong priority would send those accesses to the wrong port or answer them as holes. It aims the alias page with every combination of secure and privileged flags, and checks it again in an instance built without the security extension. A router that forgot to clear the forwarded flag would make the stub's bank bit appear in the data. A router that let non-secure accesses through would select the system port. Unprivileged hits, writes and both ends of the window catch a missing error, stale read data on writes, or a window compare that is one bit too wide.

// File: rtl/ppb_router_pkg.sv
package ppb_router_pkg;

  typedef enum logic [1:0] {
    TGT_TMR = 2'd0,
    TGT_SYS = 2'd1,
    TGT_DEF = 2'd2,
    TGT_OUT = 2'd3
  } tgt_e;

  typedef enum logic [1:0] {
    SR_CTYPE  = 2'd0,
    SR_IRQ    = 2'd1,
    SR_CTRL   = 2'd2,
    SR_SWTRIG = 2'd3
  } sysreg_e;

  typedef struct packed {
    tgt_e        tgt;
    sysreg_e     sreg;
    logic        fwd_secure;
    logic [11:0] off;
  } route_t;

  localparam logic [11:0] TMR_LO    = 12'h010;
  localparam logic [11:0] TMR_HI    = 12'h0FF;
  localparam logic [11:0] CTYPE_LO  = 12'h004;
  localparam logic [11:0] CTYPE_HI  = 12'h007;
  localparam logic [11:0] IRQ_LO    = 12'h100;
  localparam logic [11:0] IRQ_HI    = 12'h7EF;
  localparam logic [11:0] CTRL_LO   = 12'hD00;
  localparam logic [11:0] CTRL_HI   = 12'hD3F;
  localparam logic [11:0] SWTRIG_LO = 12'hF00;
  localparam logic [11:0] SWTRIG_HI = 12'hF03;

endpackage

// File: rtl/ppb_sys_subdecode.sv
module ppb_sys_subdecode
  import ppb_router_pkg::*;
(
  input  logic [11:0] off,
  output logic        tmr_hit,
  output logic        reg_hit,
  output sysreg_e     sreg
);

  logic in_ctype, in_irq, in_ctrl, in_swtrig;

  assign tmr_hit   = (off >= TMR_LO)    && (off <= TMR_HI);
  assign in_ctype  = (off >= CTYPE_LO)  && (off <= CTYPE_HI);
  assign in_irq    = (off >= IRQ_LO)    && (off <= IRQ_HI);
  assign in_ctrl   = (off >= CTRL_LO)   && (off <= CTRL_HI);
  assign in_swtrig = (off >= SWTRIG_LO) && (off <= SWTRIG_HI);

  always_comb begin
    reg_hit = 1'b1;
    sreg    = SR_CTYPE;
    if (in_irq) begin
      sreg = SR_IRQ;
    end else if (in_ctrl) begin
      sreg = SR_CTRL;
    end else if (in_swtrig) begin
      sreg = SR_SWTRIG;
    end else if (!in_ctype) begin
      reg_hit = 1'b0;
    end
  end

endmodule

// File: rtl/ppb_addr_decode.sv
module ppb_addr_decode
  import ppb_router_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned WIN_BITS  = 20,
  parameter logic [31:0] WIN_BASE  = 32'hE000_0000,
  parameter logic [31:0] SYS_OFF   = 32'h0000_E000,
  parameter logic [31:0] ALIAS_OFF = 32'h0002_E000,
  parameter bit          SEC_EXT   = 1'b1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              secure,
  output route_t            route
);

  localparam int unsigned BLK_W = WIN_BITS - 12;
  localparam logic [BLK_W-1:0] SYS_BLK   = SYS_OFF[WIN_BITS-1:12];
  localparam logic [BLK_W-1:0] ALIAS_BLK = ALIAS_OFF[WIN_BITS-1:12];

  logic             win_hit;
  logic [BLK_W-1:0] blk;
  logic             main_blk;
  logic             alias_blk;
  logic             alias_ok;
  logic             tmr_hit;
  logic             reg_hit;
  sysreg_e          sreg;

  assign win_hit   = addr[ADDR_W-1:WIN_BITS] == WIN_BASE[ADDR_W-1:WIN_BITS];
  assign blk       = addr[WIN_BITS-1:12];
  assign main_blk  = blk == SYS_BLK;
  assign alias_blk = blk == ALIAS_BLK;

  generate
    if (SEC_EXT) begin : g_alias
      assign alias_ok = alias_blk & secure;
    end else begin : g_no_alias
      assign alias_ok = 1'b0;
    end
  endgenerate

  ppb_sys_subdecode u_sub (
    .off     (addr[11:0]),
    .tmr_hit (tmr_hit),
    .reg_hit (reg_hit),
    .sreg    (sreg)
  );

  always_comb begin
    route.tgt        = TGT_OUT;
    route.sreg       = sreg;
    route.fwd_secure = secure;
    route.off        = addr[11:0];
    if (win_hit) begin
      route.tgt = TGT_DEF;
      if (main_blk) begin
        if (tmr_hit) begin
          route.tgt = TGT_TMR;
        end else if (reg_hit) begin
          route.tgt = TGT_SYS;
        end
      end else if (alias_ok && reg_hit) begin
        route.tgt        = TGT_SYS;
        route.fwd_secure = 1'b0;
      end
    end
  end

endmodule

// File: rtl/ppb_rsp_stage.sv
module ppb_rsp_stage
  import ppb_router_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  tgt_e              tgt,
  input  logic              write,
  input  logic              priv,
  input  logic [DATA_W-1:0] tmr_rdata,
  input  logic              tmr_err,
  input  logic [DATA_W-1:0] sys_rdata,
  input  logic              sys_err,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err
);

  logic              valid_d;
  logic [DATA_W-1:0] rdata_d;
  logic              err_d;
  logic [DATA_W-1:0] port_data;

  always_comb begin
    valid_d   = accept;
    port_data = '0;
    err_d     = 1'b1;
    unique case (tgt)
      TGT_TMR: begin port_data = tmr_rdata; err_d = tmr_err; end
      TGT_SYS: begin port_data = sys_rdata; err_d = sys_err; end
      TGT_DEF: begin port_data = '0;        err_d = ~priv;   end
      default: begin port_data = '0;        err_d = 1'b1;    end
    endcase
    rdata_d = (write || err_d) ? '0 : port_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= valid_d;
      if (accept) begin
        rsp_rdata <= rdata_d;
        rsp_err   <= err_d;
      end
    end
  end

endmodule

// File: rtl/ppb_router.sv
module ppb_router
  import ppb_router_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned DATA_W    = 64,
  parameter int unsigned WIN_BITS  = 20,
  parameter logic [31:0] WIN_BASE  = 32'hE000_0000,
  parameter logic [31:0] SYS_OFF   = 32'h0000_E000,
  parameter logic [31:0] ALIAS_OFF = 32'h0002_E000,
  parameter bit          SEC_EXT   = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_priv,
  input  logic              req_secure,
  output logic              tmr_sel,
  output logic              sys_sel,
  output logic [1:0]        sys_reg,
  output logic [11:0]       dn_offset,
  output logic              dn_write,
  output logic [1:0]        dn_size,
  output logic [DATA_W-1:0] dn_wdata,
  output logic              dn_priv,
  output logic              dn_secure,
  output logic              dn_orig_secure,
  input  logic [DATA_W-1:0] tmr_rdata,
  input  logic              tmr_err,
  input  logic [DATA_W-1:0] sys_rdata,
  input  logic              sys_err,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err
);

  route_t route;
  logic   accept;

  assign req_ready = 1'b1;
  assign accept    = req_valid & req_ready;

  ppb_addr_decode #(
    .ADDR_W    (ADDR_W),
    .WIN_BITS  (WIN_BITS),
    .WIN_BASE  (WIN_BASE),
    .SYS_OFF   (SYS_OFF),
    .ALIAS_OFF (ALIAS_OFF),
    .SEC_EXT   (SEC_EXT)
  ) u_dec (
    .addr   (req_addr),
    .secure (req_secure),
    .route  (route)
  );

  assign tmr_sel        = accept && (route.tgt == TGT_TMR);
  assign sys_sel        = accept && (route.tgt == TGT_SYS);
  assign sys_reg        = route.sreg;
  assign dn_offset      = route.off;
  assign dn_write       = req_write;
  assign dn_size        = req_size;
  assign dn_wdata       = req_wdata;
  assign dn_priv        = req_priv;
  assign dn_secure      = route.fwd_secure;
  assign dn_orig_secure = req_secure;

  ppb_rsp_stage #(
    .DATA_W (DATA_W)
  ) u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .tgt       (route.tgt),
    .write     (req_write),
    .priv      (req_priv),
    .tmr_rdata (tmr_rdata),
    .tmr_err   (tmr_err),
    .sys_rdata (sys_rdata),
    .sys_err   (sys_err),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .rsp_err   (rsp_err)
  );

endmodule

// File: rtl/ppb_router_chk.sv
module ppb_router_chk #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned DATA_W    = 64,
  parameter int unsigned WIN_BITS  = 20,
  parameter logic [31:0] WIN_BASE  = 32'hE000_0000,
  parameter logic [31:0] SYS_OFF   = 32'h0000_E000,
  parameter logic [31:0] ALIAS_OFF = 32'h0002_E000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_write,
  input logic              req_priv,
  input logic              req_secure,
  input logic              tmr_sel,
  input logic              sys_sel,
  input logic              dn_secure,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              rsp_err
);

  logic in_win, in_tmr, in_alias;

  assign in_win   = (req_addr >= WIN_BASE) && (req_addr <= (WIN_BASE | ((32'd1 << WIN_BITS) - 32'd1)));
  assign in_tmr   = (req_addr >= (WIN_BASE + SYS_OFF + 32'h10)) && (req_addr <= (WIN_BASE + SYS_OFF + 32'hFF));
  assign in_alias = (req_addr >= (WIN_BASE + ALIAS_OFF)) && (req_addr <= (WIN_BASE + ALIAS_OFF + 32'hFFF));

  p_one_port_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tmr_sel, sys_sel}));

  p_timer_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && in_tmr |-> tmr_sel && !sys_sel);

  p_outside_err_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !in_win |=> rsp_valid && rsp_err && (rsp_rdata == '0));

  p_alias_nonsec_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sys_sel && in_alias |-> req_secure && !dn_secure);

  p_alias_ns_unclaimed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && in_alias && !req_secure |-> !sys_sel && !tmr_sel);

  p_unpriv_unmapped_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_priv && !tmr_sel && !sys_sel |=> rsp_err);

  p_priv_unmapped_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && in_win && req_priv && !tmr_sel && !sys_sel |=> !rsp_err && (rsp_rdata == '0));

  p_rsp_next_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  p_rsp_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  p_write_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write |=> rsp_rdata == '0);

endmodule

bind ppb_router ppb_router_chk #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .WIN_BITS  (WIN_BITS),
  .WIN_BASE  (WIN_BASE),
  .SYS_OFF   (SYS_OFF),
  .ALIAS_OFF (ALIAS_OFF)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_addr   (req_addr),
  .req_write  (req_write),
  .req_priv   (req_priv),
  .req_secure (req_secure),
  .tmr_sel    (tmr_sel),
  .sys_sel    (sys_sel),
  .dn_secure  (dn_secure),
  .rsp_valid  (rsp_valid),
  .rsp_rdata  (rsp_rdata),
  .rsp_err    (rsp_err)
);

// File: tb/ppb_router_test.sv
module ppb_router_test;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [31:0] a;
    logic        w;
    logic        p;
    logic        s;
    logic [1:0]  sz;
    logic [1:0]  tgt;
    logic [63:0] rd;
    logic        e;
    logic        ds;
  } vec_t;

  localparam int NV = 24;
  // tgt: 0 timer, 1 system, 2 no port selected
  localparam vec_t V [NV] = '{
    '{32'hE000_E010, 1'b0, 1'b1, 1'b1, 2'd2, 2'd0, 64'h7100_0000_0000_0010, 1'b0, 1'b1}, // R2 low edge
    '{32'hE000_E0FF, 1'b0, 1'b1, 1'b0, 2'd0, 2'd0, 64'h7100_0000_0000_00FF, 1'b0, 1'b0}, // R2 high edge, R11
    '{32'hE000_E00F, 1'b0, 1'b1, 1'b1, 2'd2, 2'd2, 64'h0,                   1'b0, 1'b0}, // R4 hole
    '{32'hE000_E004, 1'b0, 1'b1, 1'b0, 2'd2, 2'd1, 64'h5000_0000_0000_0004, 1'b0, 1'b0}, // R3 code 0
    '{32'hE000_E100, 1'b0, 1'b1, 1'b1, 2'd2, 2'd1, 64'h5000_0101_0000_0100, 1'b0, 1'b1}, // R3 code 1 secure
    '{32'hE000_E7EC, 1'b0, 1'b1, 1'b0, 2'd2, 2'd1, 64'h5000_0001_0000_07EC, 1'b0, 1'b0}, // R3
    '{32'hE000_E7F0, 1'b0, 1'b1, 1'b0, 2'd2, 2'd2, 64'h0,                   1'b0, 1'b0}, // R4
    '{32'hE000_ED3C, 1'b0, 1'b1, 1'b0, 2'd3, 2'd1, 64'h5000_0002_0000_0D3C, 1'b0, 1'b0}, // R3 code 2, R11
    '{32'hE000_ED40, 1'b0, 1'b1, 1'b0, 2'd2, 2'd2, 64'h0,                   1'b0, 1'b0}, // R4
    '{32'hE000_EF00, 1'b0, 1'b0, 1'b0, 2'd2, 2'd1, 64'h5000_0003_0000_0F00, 1'b0, 1'b0}, // R3 code 3
    '{32'hE000_E100, 1'b0, 1'b0, 1'b0, 2'd2, 2'd1, 64'h0,                   1'b1, 1'b0}, // R10 port error
    '{32'hE000_1000, 1'b0, 1'b0, 1'b0, 2'd2, 2'd2, 64'h0,                   1'b1, 1'b0}, // R5
    '{32'hE000_1000, 1'b1, 1'b1, 1'b0, 2'd3, 2'd2, 64'h0,                   1'b0, 1'b0}, // R4 write, R11
    '{32'hE002_E100, 1'b0, 1'b1, 1'b1, 2'd2, 2'd1, 64'h5000_0001_0000_0100, 1'b0, 1'b0}, // R6
    '{32'hE002_E100, 1'b0, 1'b1, 1'b0, 2'd2, 2'd2, 64'h0,                   1'b0, 1'b0}, // R7 priv
    '{32'hE002_E100, 1'b0, 1'b0, 1'b0, 2'd2, 2'd2, 64'h0,                   1'b1, 1'b0}, // R7 unpriv
    '{32'hE002_E020, 1'b0, 1'b1, 1'b1, 2'd2, 2'd2, 64'h0,                   1'b0, 1'b0}, // R6 timer offset in alias
    '{32'hE00F_FFFF, 1'b0, 1'b1, 1'b0, 2'd0, 2'd2, 64'h0,                   1'b0, 1'b0}, // R4 window top
    '{32'hE010_0000, 1'b0, 1'b1, 1'b0, 2'd2, 2'd2, 64'h0,                   1'b1, 1'b0}, // R1 above
    '{32'hDFFF_FFFF, 1'b0, 1'b1, 1'b0, 2'd2, 2'd2, 64'h0,                   1'b1, 1'b0}, // R1 below
    '{32'hE000_E020, 1'b1, 1'b1, 1'b1, 2'd2, 2'd0, 64'h0,                   1'b0, 1'b1}, // R10 timer write
    '{32'hE000_ED00, 1'b1, 1'b0, 1'b0, 2'd2, 2'd1, 64'h0,                   1'b1, 1'b0}, // R10 write error
    '{32'hE002_EF00, 1'b0, 1'b0, 1'b1, 2'd1, 2'd1, 64'h5000_0003_0000_0F00, 1'b0, 1'b0}, // R6 unpriv secure
    '{32'hE000_EFFC, 1'b0, 1'b1, 1'b0, 2'd2, 2'd2, 64'h0,                   1'b0, 1'b0}  // R4 hole
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [1:0]  req_size = '0;
  logic [63:0] req_wdata = '0;
  logic        req_priv = 1'b0;
  logic        req_secure = 1'b0;
  logic        tmr_sel, sys_sel;
  logic [1:0]  sys_reg;
  logic [11:0] dn_offset;
  logic        dn_write, dn_priv, dn_secure, dn_orig_secure;
  logic [1:0]  dn_size;
  logic [63:0] dn_wdata;
  logic [63:0] tmr_rdata, sys_rdata;
  logic        tmr_err, sys_err;
  logic        rsp_valid, rsp_err;
  logic [63:0] rsp_rdata;

  // second instance without the security extension
  logic        b_ready, b_tsel, b_ssel, b_dw, b_dp, b_ds, b_dos, b_rv, b_re;
  logic [1:0]  b_sreg, b_dsz;
  logic [11:0] b_doff;
  logic [63:0] b_dwd, b_rd;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // downstream stubs
  assign tmr_rdata = 64'h7100_0000_0000_0000 | {52'd0, dn_offset};
  assign tmr_err   = 1'b0;
  assign sys_rdata = 64'h5000_0000_0000_0000 | {23'd0, dn_secure, 6'd0, sys_reg, 20'd0, dn_offset};
  assign sys_err   = !dn_priv && (dn_offset != 12'hF00);

  ppb_router uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_size(req_size),
    .req_wdata(req_wdata), .req_priv(req_priv), .req_secure(req_secure),
    .tmr_sel(tmr_sel), .sys_sel(sys_sel), .sys_reg(sys_reg),
    .dn_offset(dn_offset), .dn_write(dn_write), .dn_size(dn_size),
    .dn_wdata(dn_wdata), .dn_priv(dn_priv), .dn_secure(dn_secure),
    .dn_orig_secure(dn_orig_secure), .tmr_rdata(tmr_rdata), .tmr_err(tmr_err),
    .sys_rdata(sys_rdata), .sys_err(sys_err), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err)
  );

  ppb_router #(.SEC_EXT(1'b0)) uut_nosec (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(b_ready),
    .req_addr(req_addr), .req_write(req_write), .req_size(req_size),
    .req_wdata(req_wdata), .req_priv(req_priv), .req_secure(req_secure),
    .tmr_sel(b_tsel), .sys_sel(b_ssel), .sys_reg(b_sreg),
    .dn_offset(b_doff), .dn_write(b_dw), .dn_size(b_dsz),
    .dn_wdata(b_dwd), .dn_priv(b_dp), .dn_secure(b_ds),
    .dn_orig_secure(b_dos), .tmr_rdata(64'h1111), .tmr_err(1'b0),
    .sys_rdata(64'h2222), .sys_err(1'b0), .rsp_valid(b_rv),
    .rsp_rdata(b_rd), .rsp_err(b_re)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] a, input logic w, input logic p, input logic s, input logic [1:0] sz);
    req_valid  = 1'b1;
    req_addr   = a;
    req_write  = w;
    req_priv   = p;
    req_secure = s;
    req_size   = sz;
    req_wdata  = {a, ~a};
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(!rsp_valid && !tmr_sel && !sys_sel, "R12 in reset", {62'd0, rsp_valid, tmr_sel | sys_sel}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(!rsp_valid && !tmr_sel && !sys_sel && req_ready, "R12 after reset", {62'd0, rsp_valid, req_ready}, 64'd1);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(V[i].a, V[i].w, V[i].p, V[i].s, V[i].sz);
      #1;
      chk({tmr_sel, sys_sel} == ((V[i].tgt == 2'd0) ? 2'b10 : (V[i].tgt == 2'd1) ? 2'b01 : 2'b00),
          $sformatf("R2/R3 port select vec %0d", i), {62'd0, tmr_sel, sys_sel}, {62'd0, V[i].tgt});
      if (V[i].tgt != 2'd2) begin
        chk(dn_secure == V[i].ds && dn_orig_secure == V[i].s && dn_offset == V[i].a[11:0] && dn_size == V[i].sz,
            $sformatf("R6/R11 forwarded fields vec %0d", i),
            {50'd0, dn_secure, dn_orig_secure, dn_offset}, {50'd0, V[i].ds, V[i].s, V[i].a[11:0]});
      end
      @(negedge clk);
      req_valid = 1'b0;
      #1;
      chk(rsp_valid && rsp_rdata == V[i].rd && rsp_err == V[i].e,
          $sformatf("R9/R10 response vec %0d", i), rsp_rdata ^ {63'd0, rsp_err}, V[i].rd ^ {63'd0, V[i].e});
    end

    // R8: alias without the security extension
    @(negedge clk);
    drive(32'hE002_E100, 1'b0, 1'b1, 1'b1, 2'd2);
    #1;
    chk(!b_ssel && !b_tsel, "R8 no select", {62'd0, b_tsel, b_ssel}, 64'd0);
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    chk(b_rv && b_rd == 64'd0 && !b_re, "R8 priv unclaimed", b_rd, 64'd0);
    @(negedge clk);
    drive(32'hE002_E100, 1'b0, 1'b0, 1'b1, 2'd2);
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    chk(b_rv && b_re, "R8 unpriv error", {63'd0, b_re}, 64'd1);

    // R9: back-to-back requests
    @(negedge clk);
    drive(32'hE000_E010, 1'b0, 1'b1, 1'b0, 2'd2);
    @(negedge clk);
    #1;
    chk(rsp_valid && rsp_rdata == 64'h7100_0000_0000_0010, "R9 first of pair", rsp_rdata, 64'h7100_0000_0000_0010);
    drive(32'hE000_E004, 1'b0, 1'b1, 1'b0, 2'd2);
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    chk(rsp_valid && rsp_rdata == 64'h5000_0000_0000_0004, "R9 second of pair", rsp_rdata, 64'h5000_0000_0000_0004);
    @(negedge clk);
    #1;
    chk(!rsp_valid, "R9 single pulse", {63'd0, rsp_valid}, 64'd0);

    finish_run();
  end

endmodule